// File: doc/BRIEF.md
# Flash Page Staging Buffer

This block holds one page of program words while software builds the page, before a page-write engine copies it into flash. Software presents a byte-granular address pointer along with a 16-bit word. The low pointer bits above the byte-select bit choose a word slot. Slots can be filled in any order. A slot takes its first value and refuses later ones until the whole buffer is wiped. Slots that were never filled read as all ones, which is the erased flash value.

A small controller tracks the buffer's life cycle. The buffer is wiped on four events:

- reset;
- an explicit clear command;
- an EEPROM write that arrives while a page is being filled;
- the end of a page write.

While a page write runs, the contents are frozen for the engine. Loads, clears and EEPROM writes have no effect during that time.

Controller states and transitions:

- `ST_EMPTY`: no slot is filled.
  - An accepted load moves it to `ST_FILLING`.
  - `pgwr_start` moves it to `ST_WRITING`.
  - `clear_cmd` keeps it in `ST_EMPTY`.
- `ST_FILLING`: at least one slot is filled.
  - `clear_cmd` or `ee_write` wipes the buffer and returns it to `ST_EMPTY`. This has the highest priority.
  - Otherwise `pgwr_start` moves it to `ST_WRITING`.
  - Otherwise a load stays in `ST_FILLING`.
- `ST_WRITING`: a page write is in progress. `pgwr_done` wipes the buffer and returns it to `ST_EMPTY`.

Top module: `tpb_page_buffer`

## Requirements
- R1: After reset every `word_valid` bit is 0, every word of `page_data` is 16'hFFFF and `write_busy` is 0.
- R2: With `load_en` high, the word slot index is taken from `load_addr[IDX_W:1]`, where IDX_W = log2(PAGE_WORDS) (bits 4:1 for 16 words). `load_addr[0]` and all higher bits are ignored. Slot i occupies `page_data[16*i+15:16*i]`. The word and its `word_valid[i]` bit appear one cycle after the load. Slots may be loaded in any order.
- R3: A load to a slot whose valid bit is already 1 is ignored, and the first value is kept.
- R4: A slot whose valid bit is 0 reads as 16'hFFFF.
- R5: `clear_cmd` while not writing wipes all slots, which then show valid 0 and data FFFF, one cycle later.
- R6: `ee_write` while one or more slots are filled wipes all slots one cycle later.
- R7: `pgwr_start` raises `write_busy` one cycle later. While `write_busy` is 1, loads, `clear_cmd` and `ee_write` leave `page_data` and `word_valid` unchanged.
- R8: `pgwr_done` while `write_busy` is 1 wipes all slots and drops `write_busy` one cycle later.
- R9: A load presented in the same cycle as `clear_cmd`, `ee_write` (while filling) or `pgwr_start` is not stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_en | input | 1 | Load one word this cycle |
| load_addr | input | ADDR_W | Byte-granular address pointer |
| load_data | input | 16 | Word to store |
| clear_cmd | input | 1 | Wipe buffer command |
| ee_write | input | 1 | EEPROM write in progress |
| pgwr_start | input | 1 | Page write begins |
| pgwr_done | input | 1 | Page write completed |
| page_data | output | PAGE_WORDS*16 | All slot words, slot 0 in the low bits |
| word_valid | output | PAGE_WORDS | One bit per filled slot |
| write_busy | output | 1 | Page write in progress |

## Verification
Every result of this block is due exactly one clock edge after its stimulus:

- a stored word and its valid bit;
- a wipe caused by any of the four events;
- the rise and fall of `write_busy`.

The bench drives each stimulus on a falling edge and holds it across one rising edge. It removes the stimulus on the next falling edge and compares all outputs at that same falling edge, against a bench model updated from the requirements. For the freeze during a page write, the bench presents loads, clears and EEPROM writes across several edges, comparing outputs after each one, before it issues `pgwr_done`.

// File: rtl/tpb_pkg.sv
package tpb_pkg;
    localparam int WORD_W = 16;
    localparam logic [WORD_W-1:0] ERASED_WORD = '1;

    typedef enum logic [1:0] {
        ST_EMPTY   = 2'd0,
        ST_FILLING = 2'd1,
        ST_WRITING = 2'd2
    } tpb_state_e;
endpackage

// File: rtl/tpb_ctrl.sv
module tpb_ctrl
    import tpb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic load_en,
    input  logic clear_cmd,
    input  logic ee_write,
    input  logic pgwr_start,
    input  logic pgwr_done,
    output logic wipe,
    output logic accept,
    output logic busy
);
    tpb_state_e state, state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_EMPTY: begin
                if (pgwr_start)
                    state_nx = ST_WRITING;
                else if (load_en && !clear_cmd)
                    state_nx = ST_FILLING;
            end
            ST_FILLING: begin
                if (clear_cmd || ee_write)
                    state_nx = ST_EMPTY;
                else if (pgwr_start)
                    state_nx = ST_WRITING;
            end
            ST_WRITING: begin
                if (pgwr_done)
                    state_nx = ST_EMPTY;
            end
            default: state_nx = ST_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= ST_EMPTY;
        else
            state <= state_nx;
    end

    always_comb begin
        wipe   = 1'b0;
        accept = 1'b0;
        busy   = 1'b0;
        unique case (state)
            ST_EMPTY: begin
                wipe   = clear_cmd;
                accept = load_en && !clear_cmd && !pgwr_start;
            end
            ST_FILLING: begin
                wipe   = clear_cmd || ee_write;
                accept = load_en && !clear_cmd && !ee_write && !pgwr_start;
            end
            ST_WRITING: begin
                wipe = pgwr_done;
                busy = 1'b1;
            end
            default: wipe = 1'b1;
        endcase
    end
endmodule

// File: rtl/tpb_index.sv
module tpb_index #(
    parameter int PAGE_WORDS = 16,
    parameter int ADDR_W     = 16
) (
    input  logic                  accept,
    input  logic [ADDR_W-1:0]     load_addr,
    output logic [PAGE_WORDS-1:0] slot_we
);
    localparam int IDX_W = (PAGE_WORDS > 1) ? $clog2(PAGE_WORDS) : 1;

    logic [IDX_W-1:0] idx;
    logic             unused_addr_bits;

    assign idx              = load_addr[IDX_W:1];
    assign unused_addr_bits = ^{load_addr[0], load_addr[ADDR_W-1:IDX_W]};

    for (genvar i = 0; i < PAGE_WORDS; i++) begin : g_dec
        assign slot_we[i] = accept && (idx == IDX_W'(i));
    end
endmodule

// File: rtl/tpb_slot.sv
module tpb_slot
    import tpb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wipe,
    input  logic              we,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] word,
    output logic              filled
);
    always_ff @(posedge clk) begin
        if (!rst_n || wipe) begin
            word   <= ERASED_WORD;
            filled <= 1'b0;
        end else if (we && !filled) begin
            word   <= wdata;
            filled <= 1'b1;
        end
    end
endmodule

// File: rtl/tpb_page_buffer.sv
module tpb_page_buffer
    import tpb_pkg::*;
#(
    parameter int PAGE_WORDS = 16,
    parameter int ADDR_W     = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         load_en,
    input  logic [ADDR_W-1:0]            load_addr,
    input  logic [WORD_W-1:0]            load_data,
    input  logic                         clear_cmd,
    input  logic                         ee_write,
    input  logic                         pgwr_start,
    input  logic                         pgwr_done,
    output logic [PAGE_WORDS*WORD_W-1:0] page_data,
    output logic [PAGE_WORDS-1:0]        word_valid,
    output logic                         write_busy
);
    logic                  wipe, accept;
    logic [PAGE_WORDS-1:0] slot_we;

    tpb_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_en    (load_en),
        .clear_cmd  (clear_cmd),
        .ee_write   (ee_write),
        .pgwr_start (pgwr_start),
        .pgwr_done  (pgwr_done),
        .wipe       (wipe),
        .accept     (accept),
        .busy       (write_busy)
    );

    tpb_index #(.PAGE_WORDS(PAGE_WORDS), .ADDR_W(ADDR_W)) u_index (
        .accept    (accept),
        .load_addr (load_addr),
        .slot_we   (slot_we)
    );

    for (genvar i = 0; i < PAGE_WORDS; i++) begin : g_slot
        tpb_slot u_slot (
            .clk    (clk),
            .rst_n  (rst_n),
            .wipe   (wipe),
            .we     (slot_we[i]),
            .wdata  (load_data),
            .word   (page_data[i*WORD_W +: WORD_W]),
            .filled (word_valid[i])
        );
    end
endmodule

// File: rtl/tpb_page_buffer_chk.sv
module tpb_page_buffer_chk
    import tpb_pkg::*;
#(
    parameter int PAGE_WORDS = 16
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         clear_cmd,
    input logic                         ee_write,
    input logic                         pgwr_start,
    input logic                         pgwr_done,
    input logic [PAGE_WORDS*WORD_W-1:0] page_data,
    input logic [PAGE_WORDS-1:0]        word_valid,
    input logic                         write_busy
);
    // R1: first cycle out of reset shows an empty buffer
    p_reset_empty_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (word_valid == '0 && !write_busy));

    // R5: clear while not writing empties the buffer next cycle
    p_clear_wipes_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_cmd && !write_busy) |=> (word_valid == '0));

    // R6: EEPROM write while filled empties the buffer next cycle
    p_ee_wipes_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ee_write && !write_busy && word_valid != '0) |=> (word_valid == '0));

    // R7: contents frozen while a page write runs
    p_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (write_busy && !pgwr_done) |=> ($stable(word_valid) && $stable(page_data) && write_busy));

    // R7: start raises busy
    p_start_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pgwr_start && !write_busy) |=> write_busy);

    // R8: done wipes and releases
    p_done_wipes_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (write_busy && pgwr_done) |=> (!write_busy && word_valid == '0));

    for (genvar i = 0; i < PAGE_WORDS; i++) begin : g_slot_chk
        // R3: a filled slot keeps its word unless a wipe event occurs
        p_write_once_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (word_valid[i] && !clear_cmd && !ee_write && !pgwr_done)
            |=> (word_valid[i] && $stable(page_data[i*WORD_W +: WORD_W])));

        // R4: unfilled slots read erased
        p_unloaded_erased_r4: assert property (@(posedge clk) disable iff (!rst_n)
            !word_valid[i] |-> (page_data[i*WORD_W +: WORD_W] == ERASED_WORD));
    end
endmodule

bind tpb_page_buffer tpb_page_buffer_chk #(.PAGE_WORDS(PAGE_WORDS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear_cmd  (clear_cmd),
    .ee_write   (ee_write),
    .pgwr_start (pgwr_start),
    .pgwr_done  (pgwr_done),
    .page_data  (page_data),
    .word_valid (word_valid),
    .write_busy (write_busy)
);

// File: tb/tpb_page_buffer_test.sv
module tpb_page_buffer_test;
    localparam int PW = 16;
    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          load_en = 1'b0;
    logic [AW-1:0] load_addr = '0;
    logic [15:0]   load_data = '0;
    logic          clear_cmd = 1'b0;
    logic          ee_write = 1'b0;
    logic          pgwr_start = 1'b0;
    logic          pgwr_done = 1'b0;
    logic [PW*16-1:0] page_data;
    logic [PW-1:0]    word_valid;
    logic             write_busy;

    int checks = 0;
    int errors = 0;
    logic [15:0] exp_word [PW];
    logic        exp_valid [PW];
    logic        exp_busy;

    always #10 clk = ~clk;

    tpb_page_buffer #(.PAGE_WORDS(PW), .ADDR_W(AW)) uut (
        .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_addr(load_addr),
        .load_data(load_data), .clear_cmd(clear_cmd), .ee_write(ee_write),
        .pgwr_start(pgwr_start), .pgwr_done(pgwr_done), .page_data(page_data),
        .word_valid(word_valid), .write_busy(write_busy)
    );

    task automatic model_wipe();
        for (int i = 0; i < PW; i++) begin
            exp_word[i]  = 16'hFFFF;
            exp_valid[i] = 1'b0;
        end
    endtask

    task automatic compare(input string req);
        for (int i = 0; i < PW; i++) begin
            checks++;
            if (word_valid[i] !== exp_valid[i] || page_data[i*16 +: 16] !== exp_word[i]) begin
                errors++;
                $display("FAIL %s slot %0d: valid=%b data=%h expected valid=%b data=%h",
                         req, i, word_valid[i], page_data[i*16 +: 16], exp_valid[i], exp_word[i]);
            end
        end
        checks++;
        if (write_busy !== exp_busy) begin
            errors++;
            $display("FAIL %s write_busy=%b expected %b", req, write_busy, exp_busy);
        end
    endtask

    // one cycle of stimulus, then compare at the next falling edge
    task automatic load(input logic [AW-1:0] a, input logic [15:0] d, input string req);
        int idx;
        idx = int'(a[4:1]);
        load_en = 1'b1; load_addr = a; load_data = d;
        @(negedge clk);
        load_en = 1'b0;
        if (!exp_busy && !exp_valid[idx]) begin
            exp_valid[idx] = 1'b1;
            exp_word[idx]  = d;
        end
        compare(req);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        model_wipe();
        exp_busy = 1'b0;
        @(negedge clk);
        compare("R1");
        compare("R4");
    endtask

    task automatic t_any_order();
        load(16'h000A, 16'h1234, "R2");
        load(16'h0001, 16'hABCD, "R2");
        load(16'h001F, 16'h5A5A, "R2");
        load(16'h0E46, 16'h0F0F, "R2");
        compare("R4");
    endtask

    task automatic t_write_once();
        load(16'h0006, 16'h1111, "R3");
        load(16'h0007, 16'h2222, "R3");
        load(16'h0020, 16'h3333, "R3");
    endtask

    task automatic t_clear();
        clear_cmd = 1'b1; load_en = 1'b1; load_addr = 16'h0010; load_data = 16'h7777;
        @(negedge clk);
        clear_cmd = 1'b0; load_en = 1'b0;
        model_wipe();
        compare("R5");
        compare("R9");
        clear_cmd = 1'b1;
        @(negedge clk);
        clear_cmd = 1'b0;
        compare("R5");
    endtask

    task automatic t_eeprom();
        load(16'h0004, 16'hBEEF, "R2");
        load(16'h0018, 16'hCAFE, "R2");
        ee_write = 1'b1; load_en = 1'b1; load_addr = 16'h0002; load_data = 16'h4444;
        @(negedge clk);
        ee_write = 1'b0; load_en = 1'b0;
        model_wipe();
        compare("R6");
        compare("R9");
    endtask

    task automatic t_page_write();
        load(16'h0000, 16'h0101, "R2");
        load(16'h001E, 16'hF00D, "R2");
        pgwr_start = 1'b1; load_en = 1'b1; load_addr = 16'h000C; load_data = 16'h9999;
        @(negedge clk);
        pgwr_start = 1'b0; load_en = 1'b0;
        exp_busy = 1'b1;
        compare("R9");
        load(16'h0008, 16'h5555, "R7");
        clear_cmd = 1'b1;
        @(negedge clk);
        clear_cmd = 1'b0;
        compare("R7");
        ee_write = 1'b1;
        @(negedge clk);
        ee_write = 1'b0;
        compare("R7");
        pgwr_done = 1'b1;
        @(negedge clk);
        pgwr_done = 1'b0;
        exp_busy = 1'b0;
        model_wipe();
        compare("R8");
        load(16'h0000, 16'h0202, "R8");
    endtask

    task automatic t_reset_mid_fill();
        load(16'h0012, 16'h6666, "R2");
        t_reset();
    endtask

    initial begin
        exp_busy = 1'b0;
        model_wipe();
        @(negedge clk);
        t_reset();
        t_any_order();
        t_write_once();
        t_clear();
        t_eeprom();
        t_page_write();
        t_reset_mid_fill();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule